// File: doc/BRIEF.md
# Chained-Acknowledge Interrupt Vector Responder

This block is the interrupt side of a device on a multiplexed address/data bus where interrupt acknowledge is passed from device to device along a chain. Three event inputs can raise a request: a transfer count reaching its end, an attention line from the attached equipment, and a bus timeout on a missing memory reply. A rising edge on any of them latches a pending request. While that request is pending and both the interrupt-enable flag and the ready flag are high, the block drives its interrupt request output.

The processor answers by raising its data-in strobe and then its acknowledge line, which enters this block from upstream. When the acknowledge rises, the block decides once whether to keep it or pass it on. It keeps the acknowledge only if it is asserting its request at that moment. In that case it drives a fixed vector onto the data lines, raises its reply, and drops the request output. It releases all three only after the processor has dropped both the strobe and the acknowledge, and it then clears the request. If it does not keep the acknowledge, it forwards it downstream for the rest of that acknowledge cycle.

Top module: `irq_vec_responder`

## Requirements
- R1: `irq` is high exactly when a request is latched, `int_en` and `rdy` are both high and no vector is being delivered. It is low in every cycle where `rply` is high. A latched request survives `int_en` or `rdy` going low.
- R2: A 0-to-1 change on any bit of `cause` (bit 0 count end, bit 1 attention, bit 2 missing reply) latches a request in the same clock edge. A cause that stays high does not latch a new request after the previous one has been cleared.
- R3: If `iak_in` rises while `irq` is high, then from the next clock edge `rply` and `dal_oe` are high and `dal` carries the vector.
- R4: If `iak_in` rises while `irq` is low, for example with no request or with `int_en` or `rdy` low, then `iak_out` follows `iak_in` from the next edge until `iak_in` is sampled low, and `rply` stays low.
- R5: The keep-or-pass decision is made only when `iak_in` rises. A request that appears while an acknowledge is being forwarded does not stop the forwarding and does not raise `rply`.
- R6: Once raised, `rply` and the vector stay up as long as either `din` or `iak_in` is sampled high. They drop on the edge where both are sampled low.
- R7: On the edge that ends a delivery, the latched request is cleared, so `irq` goes low unless R8 applies.
- R8: A cause edge that arrives while a vector is being delivered is not lost. The request is latched again on the edge that ends the delivery.
- R9: The vector on `dal` is the `VECTOR` parameter with bits 1:0 forced to zero. When no vector is being driven, `dal` is zero and `dal_oe` is low.
- R10: After reset, `irq`, `rply`, `iak_out` and `dal_oe` are low and no request is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause | input | NCAUSE | Interrupt event inputs; rising edges latch a request |
| int_en | input | 1 | Interrupt enable flag |
| rdy | input | 1 | Device ready flag |
| din | input | 1 | Processor data-in strobe |
| iak_in | input | 1 | Acknowledge from upstream in the chain |
| iak_out | output | 1 | Acknowledge forwarded downstream |
| irq | output | 1 | Interrupt request |
| rply | output | 1 | Reply for the vector read |
| dal | output | DW | Vector on the data lines (zero when not driving) |
| dal_oe | output | 1 | Data line drive enable |

## Verification
The bench goes after the chain decision. It raises a request while an acknowledge is already being forwarded. A design that re-evaluated the decision there would split the chain, raising `rply` while downstream already holds the acknowledge. It releases `din` and `iak_in` one at a time, which catches a reply that drops on either release alone. It fires a cause edge in the middle of a delivery, which a design that cleared the request blindly would lose. It also holds a cause high across the clear, which exposes a level-sensitive latch by showing a second, spurious interrupt.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_HOLD = 2'd2
  } chain_st_t;

  localparam int CAUSE_CNT_END = 0;
  localparam int CAUSE_ATTN    = 1;
  localparam int CAUSE_NOREPLY = 2;

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NCAUSE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] cause,
  input  logic              holding,
  input  logic              done,
  output logic              req_q,
  output logic              cause_rise
);

  logic [NCAUSE-1:0] cause_q;
  logic [NCAUSE-1:0] rise_vec;
  logic              rearm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NCAUSE; gi++) begin : g_edge
      assign rise_vec[gi] = cause[gi] & ~cause_q[gi];
    end
  endgenerate

  assign cause_rise = |rise_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      rearm_q <= 1'b0;
    end else if (done) begin
      req_q   <= rearm_q | cause_rise;
      rearm_q <= 1'b0;
    end else begin
      if (cause_rise) req_q <= 1'b1;
      if (cause_rise && holding) rearm_q <= 1'b1;
    end
  end

  a_r2_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    cause_rise |=> req_q);

  a_r7_clear_after_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rearm_q && !cause_rise) |=> !req_q);

  a_r8_rearm_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rearm_q) |=> req_q);

endmodule

// File: rtl/iak_chain_fsm.sv
module iak_chain_fsm
  import irq_vec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic iak_in,
  input  logic din,
  input  logic want,
  output logic holding,
  output logic passing,
  output logic done
);

  chain_st_t st_q, st_d;
  logic      iak_q;
  logic      iak_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) iak_q <= 1'b0;
    else        iak_q <= iak_in;
  end

  assign iak_rise = iak_in & ~iak_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (iak_rise) st_d = want ? ST_HOLD : ST_PASS;
      ST_PASS: if (!iak_in)  st_d = ST_IDLE;
      ST_HOLD: if (!iak_in && !din) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign holding = (st_q == ST_HOLD);
  assign passing = (st_q == ST_PASS);
  assign done    = holding & ~iak_in & ~din;

  a_r6_hold_while_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && (iak_in || din)) |=> holding);

  a_r5_pass_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (passing && iak_in) |=> passing);

endmodule

// File: rtl/vec_driver.sv
module vec_driver #(
  parameter int          DW     = 16,
  parameter logic [DW-1:0] VECTOR = 16'o000124
) (
  input  logic          holding,
  output logic [DW-1:0] dal,
  output logic          dal_oe
);

  function automatic logic [DW-1:0] align_vec(input logic [DW-1:0] v);
    return {v[DW-1:2], 2'b00};
  endfunction

  localparam logic [DW-1:0] VEC_OUT = align_vec(VECTOR);

  assign dal_oe = holding;
  assign dal    = holding ? VEC_OUT : '0;

  always_comb begin
    if (dal_oe) a_r9_low_bits_zero: assert (dal[1:0] == 2'b00);
  end

endmodule

// File: rtl/irq_vec_responder.sv
module irq_vec_responder
  import irq_vec_pkg::*;
#(
  parameter int            NCAUSE = 3,
  parameter int            DW     = 16,
  parameter logic [DW-1:0] VECTOR = 16'o000124
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] cause,
  input  logic              int_en,
  input  logic              rdy,
  input  logic              din,
  input  logic              iak_in,
  output logic              iak_out,
  output logic              irq,
  output logic              rply,
  output logic [DW-1:0]     dal,
  output logic              dal_oe
);

  logic req_q, cause_rise, holding, passing, done;

  irq_req_latch #(.NCAUSE(NCAUSE)) u_latch (
    .clk(clk), .rst_n(rst_n), .cause(cause), .holding(holding),
    .done(done), .req_q(req_q), .cause_rise(cause_rise)
  );

  iak_chain_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .iak_in(iak_in), .din(din), .want(irq),
    .holding(holding), .passing(passing), .done(done)
  );

  vec_driver #(.DW(DW), .VECTOR(VECTOR)) u_drv (
    .holding(holding), .dal(dal), .dal_oe(dal_oe)
  );

  assign irq     = req_q & int_en & rdy & ~holding;
  assign rply    = holding;
  assign iak_out = passing & iak_in;

  a_r1_no_irq_while_reply: assert property (@(posedge clk) disable iff (!rst_n)
    rply |-> !irq);

  a_r4_chain_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(iak_out && rply));

  a_r3_reply_carries_vector: assert property (@(posedge clk) disable iff (!rst_n)
    rply |-> (dal_oe && dal != '0 || VECTOR[DW-1:2] == '0));

  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rply && !iak_out && !dal_oe));

endmodule

// File: tb/irq_vec_responder_bench.sv
module irq_vec_responder_bench;

  localparam int            DW   = 16;
  localparam logic [DW-1:0] VEC  = 16'h00AB;
  localparam logic [DW-1:0] EXPV = VEC & ~16'h0003;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cause = '0;
  logic          int_en = 1'b0, rdy = 1'b0, din = 1'b0, iak_in = 1'b0;
  logic          iak_out, irq, rply, dal_oe;
  logic [DW-1:0] dal;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic  irq;
    logic  rply;
    logic  iako;
    string tag;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  irq_vec_responder #(.NCAUSE(3), .DW(DW), .VECTOR(VEC)) u_irq_vec_responder (
    .clk(clk), .rst_n(rst_n), .cause(cause), .int_en(int_en), .rdy(rdy),
    .din(din), .iak_in(iak_in), .iak_out(iak_out), .irq(irq), .rply(rply),
    .dal(dal), .dal_oe(dal_oe)
  );

  task automatic check(input logic [DW+3:0] act, input logic [DW+3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual irq/rply/iako/oe/dal=%h expected %h", tag, act, exp);
    end
  endtask

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({irq, rply, iak_out, dal_oe, dal},
            {e.irq, e.rply, e.iako, e.rply, (e.rply ? EXPV : '0)}, e.tag);
    end
  end

  // driver: applies inputs at the falling edge and queues the result expected after the next rise
  task automatic step(input logic [2:0] c, input logic ie, input logic rd,
                      input logic d, input logic ia,
                      input logic e_irq, input logic e_rply, input logic e_iako,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cause = c; int_en = ie; rdy = rd; din = d; iak_in = ia;
    e.irq = e_irq; e.rply = e_rply; e.iako = e_iako; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check({irq, rply, iak_out, dal_oe, dal}, '0, "R10 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    //     cause   ie rd din iak  irq rply iako
    step(3'b000, 1, 1, 0, 0,   0, 0, 0, "R10 idle after reset");
    step(3'b010, 1, 1, 0, 0,   1, 0, 0, "R2 attention edge latches");
    step(3'b010, 1, 1, 1, 0,   1, 0, 0, "R1 irq held with strobe");
    step(3'b010, 1, 1, 1, 1,   0, 1, 0, "R3 capture drives vector R9");
    step(3'b010, 1, 1, 0, 1,   0, 1, 0, "R6 hold with iak only");
    step(3'b010, 1, 1, 1, 0,   0, 1, 0, "R6 hold with din only");
    step(3'b010, 1, 1, 0, 0,   0, 0, 0, "R7 release clears, R2 level ignored");
    step(3'b000, 1, 1, 0, 0,   0, 0, 0, "R2 no relatch");
    step(3'b000, 1, 1, 1, 1,   0, 0, 1, "R4 pass when idle");
    step(3'b001, 1, 1, 1, 1,   1, 0, 1, "R5 request mid-pass keeps forwarding");
    step(3'b001, 1, 1, 1, 1,   1, 0, 1, "R5 still forwarding");
    step(3'b001, 1, 1, 0, 0,   1, 0, 0, "R4 pass ends");
    step(3'b001, 1, 1, 1, 1,   0, 1, 0, "R3 capture of count-end request");
    step(3'b101, 1, 1, 1, 1,   0, 1, 0, "R8 edge during delivery");
    step(3'b101, 1, 1, 0, 0,   1, 0, 0, "R8 request restored after delivery");
    step(3'b101, 0, 1, 0, 0,   0, 0, 0, "R1 enable low masks irq");
    step(3'b101, 0, 1, 1, 1,   0, 0, 1, "R4 pass with enable low");
    step(3'b101, 1, 1, 1, 1,   1, 0, 1, "R5 enable return no capture");
    step(3'b101, 1, 1, 0, 0,   1, 0, 0, "R1 request survived masking");
    step(3'b101, 1, 0, 0, 0,   0, 0, 0, "R1 ready low masks irq");
    step(3'b101, 1, 0, 1, 1,   0, 0, 1, "R4 pass with ready low");
    step(3'b101, 1, 1, 0, 0,   1, 0, 0, "R4 pass ends ready back");
    step(3'b101, 1, 1, 1, 1,   0, 1, 0, "R3 capture again R9");
    step(3'b000, 1, 1, 0, 0,   0, 0, 0, "R7 cleared");
    step(3'b000, 1, 1, 0, 0,   0, 0, 0, "R7 stays clear");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule